// File: doc/BRIEF.md
# Dual-Depth UART FIFO Controller

This block holds the receive and transmit byte queues of a 16550-style serial port, together with the logic that decodes writes to the FIFO control register. Software can leave the queues off (single holding byte), run them at the classic depth of 16, or switch on a deep mode of 64 entries. In deep mode the receive trigger-level code takes a different meaning. The mode is reported in the top three bits of the interrupt identification register, so a driver can probe for the deep mode by writing the control register and reading those bits back.

The serial shifter, baud generator, modem lines and interrupt priority logic sit outside. The line side reaches the block through byte push and pop strobes. Software reads of the receive buffer and writes of the transmit holding register reach it through the same kind of strobes. The block raises a single receive-data-available request.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset the queues are off, deep mode is clear, both counts are 0, the IIR top bits read 000, and the request, overrun and almost-full outputs are 0.
- R2: Queue capacity is 1 when off, 16 in classic mode and 64 in deep mode. A push beyond capacity is dropped and the count stays at capacity.
- R3: Deep mode is entered only by a control write with bit 0 (enable) and bit 5 (deep) both 1 while `lcr_i` is 0. If `lcr_i` is nonzero, bit 5 of the write is ignored and the current deep state is kept, provided bit 0 is 1.
- R4: In deep mode the trigger code in control bits 7:6 selects 1, 16, 32 or 56 bytes for codes 00, 01, 10 and 11.
- R5: In classic mode the same codes select 1, 4, 8 and 14 bytes. With the queues off the level is 1.
- R6: `rda_irq_o` is 1 exactly while the receive count is at or above the current trigger level.
- R7: The IIR top bits read 111 in deep mode, 110 in classic mode and 000 when the queues are off.
- R8: A control write of 0 turns the queues off, clears deep mode and empties both queues.
- R9: A control write that changes the enable or the deep state empties both queues. Bit 1 empties the receive queue and bit 2 empties the transmit queue. An emptying write beats a push in the same cycle.
- R10: `tx_afull_o` is 1 while the queues are on and the transmit count is at least one below capacity (63 in deep mode, 15 in classic mode).
- R11: A receive push that finds the queue full, with no pop in the same cycle, sets a sticky `overrun_o`. A pulse on `lsr_rd_i` clears it, and a new drop in the same cycle wins.
- R12: Each queue is first-in first-out, and its data output shows the oldest entry. A pop of an empty queue is ignored. A push and a pop together on a full queue both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lcr_i | input | 8 | Current line control register value |
| fcr_we_i | input | 1 | FIFO control register write strobe |
| fcr_wdata_i | input | 8 | FIFO control register write data |
| lsr_rd_i | input | 1 | Line status read strobe, clears overrun |
| rx_push_i | input | 1 | Received byte from the shifter |
| rx_data_i | input | 8 | Received byte value |
| rx_pop_i | input | 1 | Software read of the receive buffer |
| rx_data_o | output | 8 | Oldest received byte |
| rx_count_o | output | 7 | Receive entries held |
| rx_empty_o | output | 1 | Receive queue empty |
| tx_push_i | input | 1 | Software write of the transmit holding register |
| tx_data_i | input | 8 | Transmit byte value |
| tx_pop_i | input | 1 | Shifter takes the next transmit byte |
| tx_data_o | output | 8 | Oldest transmit byte |
| tx_count_o | output | 7 | Transmit entries held |
| tx_empty_o | output | 1 | Transmit queue empty |
| tx_full_o | output | 1 | Transmit queue at capacity |
| tx_afull_o | output | 1 | Transmit queue one below capacity or more |
| overrun_o | output | 1 | Sticky receive overrun |
| rda_irq_o | output | 1 | Receive data available request |
| fifo_en_o | output | 1 | Queues enabled |
| ext_mode_o | output | 1 | Deep 64-entry mode active |
| iir_fifo_bits_o | output | 3 | IIR bits 7:5 |

## Verification
The bench probes the trigger threshold one byte below and one byte at each deep and classic level. A wrong level table or an off-by-one compare would raise the request a byte early or late. It writes the deep bit with a nonzero line control value: a design that ignored that guard would report 111 and empty the queues. It fills each queue to capacity and pushes past it, and pops and pushes together when full. A wrong capacity shows up as a count of 17 or 65, or as a missed overrun. A design that rejected the push-pop pair on a full queue would lose a byte. Finally, it issues emptying writes together with a push, and reset-bit writes that must leave the other queue untouched. Any cross-coupling between the two queues would show up in the counts.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  // FIFO control register write layout
  typedef struct packed {
    logic [1:0] trig;    // 7:6 receive trigger code
    logic       deep;    // 5   64-entry mode request
    logic [1:0] rsv;     // 4:3 not used here
    logic       tx_rst;  // 2   self-clearing
    logic       rx_rst;  // 1   self-clearing
    logic       en;      // 0   queue enable
  } fcr_t;

  function automatic int unsigned rx_trig_level(input logic en, input logic deep,
                                                input logic [1:0] code,
                                                input int unsigned std_d,
                                                input int unsigned ext_d);
    int unsigned lvl;
    if (!en) lvl = 1;
    else if (deep) begin
      case (code)
        2'd0:    lvl = 1;
        2'd1:    lvl = ext_d / 4;
        2'd2:    lvl = ext_d / 2;
        default: lvl = ext_d - 8;
      endcase
    end else begin
      case (code)
        2'd0:    lvl = 1;
        2'd1:    lvl = std_d / 4;
        2'd2:    lvl = std_d / 2;
        default: lvl = std_d - 2;
      endcase
    end
    return lvl;
  endfunction

endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DW        = 8,
  parameter int MAX_DEPTH = 64,
  localparam int PW       = $clog2(MAX_DEPTH),
  localparam int CW       = $clog2(MAX_DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic [CW-1:0] lim_i,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);

  logic [DW-1:0] mem_q [MAX_DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;
  logic          pop_ok, push_ok;

  assign pop_ok  = pop_i & ~flush_i & (count_q != '0);
  // full queue still takes a push when a pop frees a slot in the same cycle
  assign push_ok = push_i & ~flush_i & ((count_q < lim_i) | pop_ok);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= wr_ptr_q + PW'(1);
      if (pop_ok)  rd_ptr_q <= rd_ptr_q + PW'(1);
      case ({push_ok, pop_ok})
        2'b10:   count_q <= count_q + CW'(1);
        2'b01:   count_q <= count_q - CW'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= data_i;
  end

  assign data_o  = mem_q[rd_ptr_q];
  assign count_o = count_q;
  assign full_o  = (count_q >= lim_i);
  assign empty_o = (count_q == '0);

  a_r2_count_within_lim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= lim_i);

  a_r9_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (count_q == '0));

  a_r12_empty_pop_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == '0 && pop_i && !push_i) |=> (count_q == '0));

endmodule

// File: rtl/fcr_mode_reg.sv
module fcr_mode_reg
  import uart_fifo_pkg::*;
#(
  parameter int STD_DEPTH = 16,
  parameter int EXT_DEPTH = 64,
  localparam int CW       = $clog2(EXT_DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [7:0]    wdata_i,
  input  logic [7:0]    lcr_i,
  output logic          en_o,
  output logic          ext_o,
  output logic          flush_rx_o,
  output logic          flush_tx_o,
  output logic [CW-1:0] lim_o,
  output logic [CW-1:0] trig_o,
  output logic [2:0]    iir_hi_o
);

  fcr_t       fcr;
  logic       en_q, ext_q;
  logic [1:0] trig_q;
  logic       en_nxt, ext_nxt, mode_chg;
  logic       unused_fcr_rsv;

  assign fcr            = fcr_t'(wdata_i);
  assign unused_fcr_rsv = ^fcr.rsv;

  always_comb begin
    en_nxt   = fcr.en;
    // deep bit only honoured with the line control register cleared
    ext_nxt  = fcr.en & ((lcr_i == 8'h00) ? fcr.deep : ext_q);
    mode_chg = we_i & ((en_nxt != en_q) | (ext_nxt != ext_q));
  end

  assign flush_rx_o = mode_chg | (we_i & fcr.rx_rst);
  assign flush_tx_o = mode_chg | (we_i & fcr.tx_rst);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      ext_q  <= 1'b0;
      trig_q <= 2'b00;
    end else if (we_i) begin
      en_q   <= en_nxt;
      ext_q  <= ext_nxt;
      trig_q <= fcr.trig;
    end
  end

  assign en_o     = en_q;
  assign ext_o    = ext_q;
  assign lim_o    = !en_q ? CW'(1) : (ext_q ? CW'(EXT_DEPTH) : CW'(STD_DEPTH));
  assign trig_o   = CW'(rx_trig_level(en_q, ext_q, trig_q, STD_DEPTH, EXT_DEPTH));
  assign iir_hi_o = en_q ? {2'b11, ext_q} : 3'b000;

  a_r8_zero_write_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wdata_i == 8'h00) |=> (!en_q && !ext_q));

  a_r3_lcr_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && lcr_i != 8'h00 && wdata_i[0]) |=> $stable(ext_q));

  a_r7_deep_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_q |-> en_q);

endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl #(
  parameter int DW        = 8,
  parameter int STD_DEPTH = 16,
  parameter int EXT_DEPTH = 64,
  localparam int CW       = $clog2(EXT_DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    lcr_i,
  input  logic          fcr_we_i,
  input  logic [7:0]    fcr_wdata_i,
  input  logic          lsr_rd_i,
  input  logic          rx_push_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rx_pop_i,
  output logic [DW-1:0] rx_data_o,
  output logic [CW-1:0] rx_count_o,
  output logic          rx_empty_o,
  input  logic          tx_push_i,
  input  logic [DW-1:0] tx_data_i,
  input  logic          tx_pop_i,
  output logic [DW-1:0] tx_data_o,
  output logic [CW-1:0] tx_count_o,
  output logic          tx_empty_o,
  output logic          tx_full_o,
  output logic          tx_afull_o,
  output logic          overrun_o,
  output logic          rda_irq_o,
  output logic          fifo_en_o,
  output logic          ext_mode_o,
  output logic [2:0]    iir_fifo_bits_o
);

  logic          flush_rx, flush_tx;
  logic [CW-1:0] lim, trig;
  logic          rx_full, rx_drop;
  logic          overrun_q;

  fcr_mode_reg #(
    .STD_DEPTH (STD_DEPTH),
    .EXT_DEPTH (EXT_DEPTH)
  ) u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (fcr_we_i),
    .wdata_i    (fcr_wdata_i),
    .lcr_i      (lcr_i),
    .en_o       (fifo_en_o),
    .ext_o      (ext_mode_o),
    .flush_rx_o (flush_rx),
    .flush_tx_o (flush_tx),
    .lim_o      (lim),
    .trig_o     (trig),
    .iir_hi_o   (iir_fifo_bits_o)
  );

  byte_fifo #(.DW(DW), .MAX_DEPTH(EXT_DEPTH)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush_rx),
    .lim_i   (lim),
    .push_i  (rx_push_i),
    .data_i  (rx_data_i),
    .pop_i   (rx_pop_i),
    .data_o  (rx_data_o),
    .count_o (rx_count_o),
    .full_o  (rx_full),
    .empty_o (rx_empty_o)
  );

  byte_fifo #(.DW(DW), .MAX_DEPTH(EXT_DEPTH)) u_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush_tx),
    .lim_i   (lim),
    .push_i  (tx_push_i),
    .data_i  (tx_data_i),
    .pop_i   (tx_pop_i),
    .data_o  (tx_data_o),
    .count_o (tx_count_o),
    .full_o  (tx_full_o),
    .empty_o (tx_empty_o)
  );

  assign rx_drop = rx_push_i & ~flush_rx & rx_full & ~(rx_pop_i & ~rx_empty_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       overrun_q <= 1'b0;
    else if (rx_drop)  overrun_q <= 1'b1;
    else if (lsr_rd_i) overrun_q <= 1'b0;
  end

  assign overrun_o  = overrun_q;
  assign rda_irq_o  = (rx_count_o >= trig);
  assign tx_afull_o = fifo_en_o & (tx_count_o >= lim - CW'(1));

  a_r11_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_q && !lsr_rd_i) |=> overrun_q);

  a_r11_drop_sets_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push_i && rx_full && !rx_pop_i && !fcr_we_i) |=> overrun_q);

  a_r6_no_irq_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_empty_o |-> !rda_irq_o);

endmodule

// File: tb/test_uart_fifo_ctl.sv
`timescale 1ns/1ps
module test_uart_fifo_ctl;

  localparam int CLK_PERIOD = 8;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] lcr_i = '0;
  logic       fcr_we_i = 1'b0;
  logic [7:0] fcr_wdata_i = '0;
  logic       lsr_rd_i = 1'b0;
  logic       rx_push_i = 1'b0;
  logic [7:0] rx_data_i = '0;
  logic       rx_pop_i = 1'b0;
  logic [7:0] rx_data_o;
  logic [6:0] rx_count_o;
  logic       rx_empty_o;
  logic       tx_push_i = 1'b0;
  logic [7:0] tx_data_i = '0;
  logic       tx_pop_i = 1'b0;
  logic [7:0] tx_data_o;
  logic [6:0] tx_count_o;
  logic       tx_empty_o, tx_full_o, tx_afull_o;
  logic       overrun_o, rda_irq_o, fifo_en_o, ext_mode_o;
  logic [2:0] iir_fifo_bits_o;

  uart_fifo_ctl i_uart_fifo_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .lcr_i(lcr_i),
    .fcr_we_i(fcr_we_i), .fcr_wdata_i(fcr_wdata_i), .lsr_rd_i(lsr_rd_i),
    .rx_push_i(rx_push_i), .rx_data_i(rx_data_i), .rx_pop_i(rx_pop_i),
    .rx_data_o(rx_data_o), .rx_count_o(rx_count_o), .rx_empty_o(rx_empty_o),
    .tx_push_i(tx_push_i), .tx_data_i(tx_data_i), .tx_pop_i(tx_pop_i),
    .tx_data_o(tx_data_o), .tx_count_o(tx_count_o), .tx_empty_o(tx_empty_o),
    .tx_full_o(tx_full_o), .tx_afull_o(tx_afull_o), .overrun_o(overrun_o),
    .rda_irq_o(rda_irq_o), .fifo_en_o(fifo_en_o), .ext_mode_o(ext_mode_o),
    .iir_fifo_bits_o(iir_fifo_bits_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int checks = 0;
  int failures = 0;
  bit run_chk = 1'b0;
  bit done = 1'b0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // ---------------- reference model ----------------
  bit         m_en, m_ext, m_ovr;
  bit [1:0]   m_trig;
  logic [7:0] m_rxq[$];
  logic [7:0] m_txq[$];

  function automatic int m_depth();
    if (!m_en) return 1;
    return m_ext ? 64 : 16;
  endfunction

  function automatic int m_level();
    if (!m_en) return 1;
    if (m_ext) case (m_trig) 0: return 1; 1: return 16; 2: return 32; default: return 56; endcase
    case (m_trig) 0: return 1; 1: return 4; 2: return 8; default: return 14; endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    int  d;
    bit  frx, ftx, ne, nx, pop_ok, push_ok;
    if (!rst_ni) begin
      m_en = 0; m_ext = 0; m_ovr = 0; m_trig = 0;
      m_rxq.delete(); m_txq.delete();
    end else begin
      d = m_depth();
      frx = 0; ftx = 0;
      if (fcr_we_i) begin
        ne = fcr_wdata_i[0];
        nx = ne && ((lcr_i == 0) ? fcr_wdata_i[5] : m_ext);
        if (ne != m_en || nx != m_ext) begin frx = 1; ftx = 1; end
        if (fcr_wdata_i[1]) frx = 1;
        if (fcr_wdata_i[2]) ftx = 1;
        m_en = ne; m_ext = nx; m_trig = fcr_wdata_i[7:6];
      end
      if (frx) m_rxq.delete();
      else begin
        pop_ok  = rx_pop_i && m_rxq.size() > 0;
        push_ok = rx_push_i && (m_rxq.size() < d || pop_ok);
        if (pop_ok) void'(m_rxq.pop_front());
        if (push_ok) m_rxq.push_back(rx_data_i);
        if (rx_push_i && !push_ok) m_ovr = 1;
        else if (lsr_rd_i) m_ovr = 0;
      end
      if (frx && lsr_rd_i) m_ovr = 0;
      if (ftx) m_txq.delete();
      else begin
        pop_ok  = tx_pop_i && m_txq.size() > 0;
        push_ok = tx_push_i && (m_txq.size() < d || pop_ok);
        if (pop_ok) void'(m_txq.pop_front());
        if (push_ok) m_txq.push_back(tx_data_i);
      end
    end
  end

  // compare on every cycle, half a period after the active edge
  always @(negedge clk_i) begin
    if (rst_ni && run_chk && !done) begin
      chk("R2",  "rx_count", rx_count_o, m_rxq.size());
      chk("R2",  "tx_count", tx_count_o, m_txq.size());
      chk("R2",  "tx_full", tx_full_o, m_en ? (m_txq.size() >= m_depth()) : (m_txq.size() >= 1));
      chk("R12", "rx_empty", rx_empty_o, m_rxq.size() == 0);
      chk("R12", "tx_empty", tx_empty_o, m_txq.size() == 0);
      chk("R6",  "rda_irq", rda_irq_o, m_rxq.size() >= m_level());
      chk("R7",  "iir_bits", iir_fifo_bits_o, m_en ? (m_ext ? 7 : 6) : 0);
      chk("R3",  "ext_mode", ext_mode_o, m_ext);
      chk("R8",  "fifo_en", fifo_en_o, m_en);
      chk("R10", "tx_afull", tx_afull_o, m_en && (m_txq.size() >= m_depth() - 1));
      chk("R11", "overrun", overrun_o, m_ovr);
      if (m_rxq.size() > 0) chk("R12", "rx_head", rx_data_o, m_rxq[0]);
      if (m_txq.size() > 0) chk("R12", "tx_head", tx_data_o, m_txq[0]);
    end
  end

  // ---------------- stimulus ----------------
  task automatic drive(input bit fw, input logic [7:0] fv, input bit rp, input logic [7:0] rd,
                       input bit rg, input bit tp, input logic [7:0] td, input bit tg,
                       input bit lr);
    @(posedge clk_i); #2;
    fcr_we_i = fw; fcr_wdata_i = fv; rx_push_i = rp; rx_data_i = rd; rx_pop_i = rg;
    tx_push_i = tp; tx_data_i = td; tx_pop_i = tg; lsr_rd_i = lr;
  endtask

  task automatic idle();                   drive(0, 0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic fcr_wr(input logic [7:0] v); drive(1, v, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic rx_put(input logic [7:0] b); drive(0, 0, 1, b, 0, 0, 0, 0, 0); endtask
  task automatic rx_get();                 drive(0, 0, 0, 0, 1, 0, 0, 0, 0); endtask
  task automatic tx_put(input logic [7:0] b); drive(0, 0, 0, 0, 0, 1, b, 0, 0); endtask
  task automatic lsr_read();               drive(0, 0, 0, 0, 0, 0, 0, 0, 1); endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired t=%0t", $time);
    finish_run();
  end

  initial begin
    int lv[4];
    lv[0] = 1; lv[1] = 16; lv[2] = 32; lv[3] = 56;
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    @(posedge clk_i); #2;
    // R1 reset state
    chk("R1", "rx_count", rx_count_o, 0);
    chk("R1", "tx_count", tx_count_o, 0);
    chk("R1", "iir_bits", iir_fifo_bits_o, 0);
    chk("R1", "ext_mode", ext_mode_o, 0);
    chk("R1", "irq/ovr/afull", {rda_irq_o, overrun_o, tx_afull_o}, 0);
    run_chk = 1'b1;

    // queues off: single holding byte
    rx_put(8'hA1); rx_put(8'hA2); rx_put(8'hA3); idle();
    chk("R2",  "off rx_count", rx_count_o, 1);
    chk("R11", "off overrun", overrun_o, 1);
    chk("R12", "off rx_head", rx_data_o, 8'hA1);
    lsr_read(); idle();
    chk("R11", "overrun cleared", overrun_o, 0);
    rx_get(); idle();

    // classic mode, trigger code 11
    fcr_wr(8'hC1); idle();
    chk("R7", "classic iir", iir_fifo_bits_o, 6);
    for (int i = 0; i < 13; i++) rx_put(8'h10 + 8'(i));
    idle();
    chk("R5", "classic 13 below 14", rda_irq_o, 0);
    rx_put(8'h1D); idle();
    chk("R5", "classic 14 at 14", rda_irq_o, 1);
    rx_put(8'h1E); rx_put(8'h1F); rx_put(8'hEE); idle();
    chk("R2",  "classic cap 16", rx_count_o, 16);
    chk("R11", "classic overrun", overrun_o, 1);
    drive(0, 0, 1, 8'h20, 1, 0, 0, 0, 1); idle();
    chk("R12", "full push+pop", rx_count_o, 16);
    chk("R11", "lsr clear", overrun_o, 0);
    for (int i = 0; i < 16; i++) begin
      chk("R12", "fifo order", rx_data_o, 8'h11 + 8'(i));
      rx_get(); idle();
    end
    rx_get(); idle();
    chk("R12", "pop empty", rx_count_o, 0);

    // guard: deep bit ignored with nonzero line control
    lcr_i = 8'h03;
    rx_put(8'h55); fcr_wr(8'h21); idle();
    chk("R3", "lcr guard ext", ext_mode_o, 0);
    chk("R3", "lcr guard no flush", rx_count_o, 1);
    lcr_i = 8'h00;
    fcr_wr(8'h21); idle();
    chk("R3", "deep entered", ext_mode_o, 1);
    chk("R7", "deep iir", iir_fifo_bits_o, 7);
    chk("R9", "mode change flush", rx_count_o, 0);

    // deep trigger levels
    for (int c = 0; c < 4; c++) begin
      fcr_wr({2'(c), 6'b100111}); idle();
      for (int i = 0; i < lv[c] - 1; i++) rx_put(8'(i));
      idle();
      chk("R4", "deep below level", rda_irq_o, 0);
      rx_put(8'h77); idle();
      chk("R4", "deep at level", rda_irq_o, 1);
      rx_get(); idle();
      chk("R6", "deep drop below", rda_irq_o, 0);
    end

    // transmit capacity and almost-full
    for (int i = 0; i < 62; i++) tx_put(8'(i));
    idle();
    chk("R10", "afull at 62", tx_afull_o, 0);
    tx_put(8'd62); idle();
    chk("R10", "afull at 63", tx_afull_o, 1);
    tx_put(8'd63); tx_put(8'd99); idle();
    chk("R2", "deep cap 64", tx_count_o, 64);
    chk("R2", "tx full", tx_full_o, 1);
    drive(0, 0, 0, 0, 0, 1, 8'd100, 1, 0); idle();
    chk("R12", "tx full push+pop", tx_count_o, 64);
    chk("R12", "tx head", tx_data_o, 1);
    fcr_wr(8'h25); idle();
    chk("R9", "tx reset bit", tx_count_o, 0);
    chk("R9", "rx kept", rx_count_o, 55);
    chk("R9", "deep kept", ext_mode_o, 1);

    // mixed traffic
    for (int i = 0; i < 4000; i++) begin
      bit fw, rp, rg, tp, tg, lr;
      logic [7:0] fv;
      int bias;
      bias = ((i / 400) % 2 == 0) ? 70 : 30;
      fw = ($urandom_range(99) == 0);
      fv = 8'($urandom);
      if ($urandom_range(4) != 0) fv[0] = 1'b1;
      if (fw) lcr_i = ($urandom_range(3) == 0) ? 8'h03 : 8'h00;
      rp = ($urandom_range(99) < bias);
      rg = ($urandom_range(99) < 100 - bias);
      tp = ($urandom_range(99) < bias);
      tg = ($urandom_range(99) < 100 - bias);
      lr = ($urandom_range(19) == 0);
      drive(fw, fv, rp, 8'($urandom), rg, tp, 8'($urandom), tg, lr);
    end
    lcr_i = 8'h00;
    idle();

    // zero write with a push in the same cycle
    fcr_wr(8'h01); rx_put(8'h31); tx_put(8'h32);
    drive(1, 8'h00, 1, 8'h33, 0, 1, 8'h34, 0, 0); idle();
    chk("R8", "zero write en", fifo_en_o, 0);
    chk("R8", "zero write iir", iir_fifo_bits_o, 0);
    chk("R9", "flush beats push rx", rx_count_o, 0);
    chk("R8", "zero write tx", tx_count_o, 0);
    idle();
    done = 1'b1;
    finish_run();
  end

endmodule